// File: doc/BRIEF.md
# Fan Curve PWM Controller

This block drives a set of fan PWM outputs (two by default) from temperature readings without software in the loop. Every output picks one thermal input lane and compares it against four temperature thresholds. One threshold set is shared by all outputs. The comparison places the output in one of four speed levels: off, low, high and full. Off always means a duty of 0, and full always means the all-ones duty. The low and high duty values are set per output.

Inside the band between two thresholds, the chosen level depends on the direction of the temperature. While the temperature rises, the output takes the lower of the two neighbouring levels. While it falls, the output takes the higher one. This keeps a fan from toggling around a single trip point. The direction is tracked per output by comparing each new sample with the previous sample.

Temperature samples are taken on a strobe. The PWM period comes from a free-running counter that all outputs share. A new duty is loaded only at the period boundary, so a period never carries a partial duty.

Top module: `fan_curve_pwm`

## Requirements
- R1: A shared period counter is 0 after reset, advances by one every clock and wraps from 255 to 0. `pwm_out[i]` is high exactly when the counter is below `duty_cur[i]`. A duty of 255 gives a constant high output and a duty of 0 a constant low output.
- R2: `duty_cur[i]` changes only on the clock edge where the counter goes from 255 to 0. At that edge it takes the duty of the output's current level. At all other times it holds.
- R3: While `rst_n` is low, at a clock edge, every output returns to the off level with `duty_cur` 0. Its direction returns to rising and its stored previous sample to 0.
- R4: On `sample_stb`, output i reads lane `src_sel[i*2 +: 2]` of `temp_in`. Lane k occupies bits `k*8 +: 8`.
- R5: On `sample_stb`, a sample above the previous one sets the direction to rising and a sample below it sets falling. An equal sample keeps the direction. The new direction applies to the same sample.
- R6: A sample at or above `thr_full` selects the full level (duty 255) in either direction.
- R7: A sample at or above `thr_high` and below `thr_full` selects the high level (`duty_hi[i*8 +: 8]`) when rising and full when falling.
- R8: A sample at or above `thr_low` and below `thr_high` selects the low level (`duty_lo[i*8 +: 8]`) when rising and high when falling.
- R9: A sample at or above `thr_off` and below `thr_low` selects off when rising and low when falling.
- R10: A sample below `thr_off` selects off in either direction.
- R11: The level is updated only on `sample_stb`. At that strobe, if `mode_ctl[i*2 +: 2]` is 2 the output is automatic. Any other value forces the off level, and the direction and previous sample still update.
- R12: The outputs share the threshold inputs but have independent lanes, duty values, directions and levels.

Thresholds are assumed ordered off <= low <= high <= full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_stb | input | 1 | Take a new temperature sample on every output |
| temp_in | input | 32 | Four 8-bit temperature lanes |
| src_sel | input | 4 | 2-bit lane select per output |
| mode_ctl | input | 4 | 2-bit mode per output, 2 = automatic |
| thr_off | input | 8 | Off-level threshold, shared |
| thr_low | input | 8 | Low-level threshold, shared |
| thr_high | input | 8 | High-level threshold, shared |
| thr_full | input | 8 | Full-level threshold, shared |
| duty_hi | input | 16 | 8-bit high-level duty per output |
| duty_lo | input | 16 | 8-bit low-level duty per output |
| pwm_out | output | 2 | PWM waveform per output |
| duty_cur | output | 16 | 8-bit duty in force per output |

## Verification
The bench builds the block with its defaults: 8-bit data, four lanes and two outputs. With these values the 256-cycle period fits many times into a short run, so the bench can count a full period of PWM high cycles. It can also time a strobe in the middle of a period against a bench-side model of the counter. With two outputs, one output can walk the rising and falling bands while the other walks a different path, which shows the shared thresholds do not couple their levels. With four lanes, switching the select onto an unused lane shows the lane selection at the duty output.

// File: rtl/fcp_pkg.sv
// Shared types for the fan curve PWM controller.
// Assumes: level codes are ordered from slowest to fastest.
package fcp_pkg;
    typedef enum logic [1:0] {
        LVL_OFF  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_FULL = 2'd3
    } fan_lvl_e;

    localparam int          MODE_W    = 2;
    localparam logic [1:0]  MODE_AUTO = 2'd2;
endpackage

// File: rtl/fcp_period_ctr.sv
// Free-running period counter shared by all PWM channels.
// Assumes: the period is 2**DW clocks; wrap marks the last count.
module fcp_period_ctr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] cnt,
    output logic          wrap
);
    localparam logic [DW-1:0] CNT_MAX = '1;

    // Advance the counter every clock; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Flag the final count of a period.
    assign wrap = (cnt == CNT_MAX);
endmodule

// File: rtl/fcp_level_track.sv
// Per-output direction tracker and four-level speed selector.
// Assumes: thresholds ordered off <= low <= high <= full; samples only
// change state on smp_stb.
module fcp_level_track
    import fcp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  logic          auto_en,
    input  logic [DW-1:0] temp,
    input  logic [DW-1:0] thr_off,
    input  logic [DW-1:0] thr_low,
    input  logic [DW-1:0] thr_high,
    input  logic [DW-1:0] thr_full,
    output fan_lvl_e      lvl
);
    logic [DW-1:0] prev_q;
    logic          rising_q;
    logic          rise_nx;
    fan_lvl_e      lvl_nx;

    // Direction of the new sample; equal samples keep the old direction.
    always_comb begin
        if (temp > prev_q)      rise_nx = 1'b1;
        else if (temp < prev_q) rise_nx = 1'b0;
        else                    rise_nx = rising_q;
    end

    // Band lookup: rising picks the lower neighbour, falling the upper.
    always_comb begin
        if (temp >= thr_full)      lvl_nx = LVL_FULL;
        else if (temp >= thr_high) lvl_nx = rise_nx ? LVL_HIGH : LVL_FULL;
        else if (temp >= thr_low)  lvl_nx = rise_nx ? LVL_LOW  : LVL_HIGH;
        else if (temp >= thr_off)  lvl_nx = rise_nx ? LVL_OFF  : LVL_LOW;
        else                       lvl_nx = LVL_OFF;
    end

    // Register sample, direction and level on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            rising_q <= 1'b1;
            lvl      <= LVL_OFF;
        end else if (smp_stb) begin
            prev_q   <= temp;
            rising_q <= rise_nx;
            lvl      <= auto_en ? lvl_nx : LVL_OFF;
        end
    end
endmodule

// File: rtl/fcp_pwm_chan.sv
// One PWM channel: loads its duty at the period boundary and compares
// it with the shared counter.
// Assumes: wrap is high during the last count of each period.
module fcp_pwm_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] duty_tgt,
    output logic [DW-1:0] duty_q,
    output logic          pwm
);
    localparam logic [DW-1:0] DUTY_MAX = '1;

    // Take the new duty only as the counter rolls over.
    always_ff @(posedge clk) begin
        if (!rst_n)    duty_q <= '0;
        else if (wrap) duty_q <= duty_tgt;
    end

    // Compare against the counter; the top duty is held constantly high.
    assign pwm = (duty_q == DUTY_MAX) || (cnt < duty_q);
endmodule

// File: rtl/fan_curve_pwm.sv
// Top of the fan curve PWM controller: lane selection, level tracking,
// duty lookup and PWM generation for NUM_OUT outputs sharing one
// threshold set and one period counter.
// Assumes: src_sel values at or above NUM_TEMP fall back to lane 0.
module fan_curve_pwm
    import fcp_pkg::*;
#(
    parameter int DW       = 8,
    parameter int NUM_TEMP = 4,
    parameter int NUM_OUT  = 2,
    localparam int SEL_W   = (NUM_TEMP > 1) ? $clog2(NUM_TEMP) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic [NUM_TEMP*DW-1:0]   temp_in,
    input  logic [NUM_OUT*SEL_W-1:0] src_sel,
    input  logic [NUM_OUT*MODE_W-1:0] mode_ctl,
    input  logic [DW-1:0]            thr_off,
    input  logic [DW-1:0]            thr_low,
    input  logic [DW-1:0]            thr_high,
    input  logic [DW-1:0]            thr_full,
    input  logic [NUM_OUT*DW-1:0]    duty_hi,
    input  logic [NUM_OUT*DW-1:0]    duty_lo,
    output logic [NUM_OUT-1:0]       pwm_out,
    output logic [NUM_OUT*DW-1:0]    duty_cur
);
    localparam logic [DW-1:0] DUTY_FULL = '1;

    logic [DW-1:0]         period_cnt;
    logic                  wrap;
    logic [DW-1:0]         lanes [NUM_TEMP];
    logic [NUM_OUT*DW-1:0] temp_sel;
    logic [NUM_OUT*2-1:0]  lvl_bus;

    fcp_period_ctr #(.DW(DW)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (period_cnt),
        .wrap (wrap)
    );

    for (genvar k = 0; k < NUM_TEMP; k++) begin : g_lane
        assign lanes[k] = temp_in[k*DW +: DW];
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        logic [SEL_W-1:0] sel;
        logic [DW-1:0]    t_pick;
        logic [DW-1:0]    tgt;
        fan_lvl_e         lvl_q;

        assign sel = src_sel[i*SEL_W +: SEL_W];

        // Route the selected lane, guarding out-of-range selects.
        always_comb begin
            if (int'(sel) < NUM_TEMP) t_pick = lanes[sel];
            else                      t_pick = lanes[0];
        end

        assign temp_sel[i*DW +: DW] = t_pick;

        fcp_level_track #(.DW(DW)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_stb (sample_stb),
            .auto_en (mode_ctl[i*MODE_W +: MODE_W] == MODE_AUTO),
            .temp    (t_pick),
            .thr_off (thr_off),
            .thr_low (thr_low),
            .thr_high(thr_high),
            .thr_full(thr_full),
            .lvl     (lvl_q)
        );

        assign lvl_bus[i*2 +: 2] = lvl_q;

        // Map the level to its duty value.
        always_comb begin
            unique case (lvl_q)
                LVL_FULL: tgt = DUTY_FULL;
                LVL_HIGH: tgt = duty_hi[i*DW +: DW];
                LVL_LOW:  tgt = duty_lo[i*DW +: DW];
                default:  tgt = '0;
            endcase
        end

        fcp_pwm_chan #(.DW(DW)) u_pwm (
            .clk     (clk),
            .rst_n   (rst_n),
            .wrap    (wrap),
            .cnt     (period_cnt),
            .duty_tgt(tgt),
            .duty_q  (duty_cur[i*DW +: DW]),
            .pwm     (pwm_out[i])
        );
    end
endmodule

// File: rtl/fcp_chk.sv
// Property checker for fan_curve_pwm, attached by bind.
// Assumes: it observes internal nets of the top without driving them.
module fcp_chk
    import fcp_pkg::*;
#(
    parameter int DW      = 8,
    parameter int NUM_OUT = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sample_stb,
    input logic [NUM_OUT*MODE_W-1:0] mode_ctl,
    input logic [DW-1:0]             thr_off,
    input logic [DW-1:0]             thr_full,
    input logic [NUM_OUT*DW-1:0]     temp_sel,
    input logic [NUM_OUT*2-1:0]      lvl_bus,
    input logic                      wrap,
    input logic [NUM_OUT*DW-1:0]     duty_cur,
    input logic [NUM_OUT-1:0]        pwm_out
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
        // R2
        duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wrap |=> $stable(duty_cur[i*DW +: DW]));

        // R1
        zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_cur[i*DW +: DW] == '0) |-> !pwm_out[i]);

        // R1
        full_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_cur[i*DW +: DW] == '1) |-> pwm_out[i]);

        // R10
        below_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_stb && temp_sel[i*DW +: DW] < thr_off)
            |=> (lvl_bus[i*2 +: 2] == LVL_OFF));

        // R6
        at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_stb && mode_ctl[i*MODE_W +: MODE_W] == MODE_AUTO
             && temp_sel[i*DW +: DW] >= thr_full)
            |=> (lvl_bus[i*2 +: 2] == LVL_FULL));

        // R11
        manual_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_stb && mode_ctl[i*MODE_W +: MODE_W] != MODE_AUTO)
            |=> (lvl_bus[i*2 +: 2] == LVL_OFF));
    end
endmodule

bind fan_curve_pwm fcp_chk #(.DW(DW), .NUM_OUT(NUM_OUT)) u_fcp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_stb(sample_stb),
    .mode_ctl  (mode_ctl),
    .thr_off   (thr_off),
    .thr_full  (thr_full),
    .temp_sel  (temp_sel),
    .lvl_bus   (lvl_bus),
    .wrap      (wrap),
    .duty_cur  (duty_cur),
    .pwm_out   (pwm_out)
);

// File: tb/fan_curve_pwm_bench.sv
// Self-checking bench for fan_curve_pwm with default parameters.
module fan_curve_pwm_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 260;
    localparam int NVEC       = 14;

    // Row: {lane0 temp, lane2 temp, expected duty out0, expected duty out1}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd30,  8'd120, 8'd0,   8'd255},
        {8'd50,  8'd85,  8'd0,   8'd255},
        {8'd70,  8'd65,  8'd90,  8'd200},
        {8'd90,  8'd45,  8'd180, 8'd50},
        {8'd110, 8'd45,  8'd255, 8'd50},
        {8'd95,  8'd50,  8'd255, 8'd0},
        {8'd95,  8'd62,  8'd255, 8'd50},
        {8'd75,  8'd99,  8'd180, 8'd200},
        {8'd55,  8'd20,  8'd90,  8'd0},
        {8'd35,  8'd39,  8'd0,   8'd0},
        {8'd60,  8'd41,  8'd90,  8'd0},
        {8'd80,  8'd61,  8'd180, 8'd50},
        {8'd100, 8'd61,  8'd255, 8'd50},
        {8'd40,  8'd79,  8'd90,  8'd50}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [7:0]  lane [4];
    logic [1:0]  sel0, sel1, mode0, mode1;
    logic [7:0]  thr_off, thr_low, thr_high, thr_full;
    logic [7:0]  hi0, hi1, lo0, lo1;
    logic [1:0]  pwm_out;
    logic [15:0] duty_cur;
    logic [31:0] cyc;
    int          checks = 0;
    int          errors = 0;
    int          wd = 0;
    string       vtag [NVEC];

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_curve_pwm u_fan_curve_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb),
        .temp_in   ({lane[3], lane[2], lane[1], lane[0]}),
        .src_sel   ({sel1, sel0}),
        .mode_ctl  ({mode1, mode0}),
        .thr_off   (thr_off),
        .thr_low   (thr_low),
        .thr_high  (thr_high),
        .thr_full  (thr_full),
        .duty_hi   ({hi1, hi0}),
        .duty_lo   ({lo1, lo0}),
        .pwm_out   (pwm_out),
        .duty_cur  (duty_cur)
    );

    // Model of the period counter from R1.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(logic [7:0] t0, logic [7:0] t2, logic [7:0] t3);
        @(negedge clk);
        lane[0] = t0; lane[2] = t2; lane[3] = t3;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic count_high(int idx, output int n);
        n = 0;
        repeat (256) begin
            @(negedge clk);
            n = n + int'(pwm_out[idx]);
        end
    endtask

    initial begin
        int n;
        vtag = '{"R10 R6", "R9 R7", "R8 R4", "R7 R9", "R6 R5", "R7 R9 R12",
                 "R5 R8", "R8 R7", "R9 R10", "R10", "R8 R9", "R7 R8",
                 "R6 R5", "R9 R12"};
        lane[0] = 8'd0; lane[1] = 8'd250; lane[2] = 8'd0; lane[3] = 8'd250;
        sel0 = 2'd0; sel1 = 2'd2; mode0 = 2'd2; mode1 = 2'd2;
        thr_off = 8'd40; thr_low = 8'd60; thr_high = 8'd80; thr_full = 8'd100;
        hi0 = 8'd180; lo0 = 8'd90; hi1 = 8'd200; lo1 = 8'd50;

        repeat (4) @(negedge clk);
        // R3: reset state
        check("R3 reset duty0", int'(duty_cur[7:0]), 0);
        check("R3 reset duty1", int'(duty_cur[15:8]), 0);
        check("R3 reset pwm", int'(pwm_out), 0);
        rst_n = 1'b1;

        // Table walk: rising and falling bands on both outputs.
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][31:24], VEC[v][23:16], lane[3]);
            check({vtag[v], " out0"}, int'(duty_cur[7:0]),  int'(VEC[v][15:8]));
            check({vtag[v], " out1"}, int'(duty_cur[15:8]), int'(VEC[v][7:0]));
        end

        // R1: high cycles per period equal the duty.
        count_high(0, n); check("R1 pwm0 count duty 90", n, 90);
        count_high(1, n); check("R1 pwm1 count duty 50", n, 50);
        apply(8'd200, lane[2], lane[3]);
        check("R6 out0 full", int'(duty_cur[7:0]), 255);
        count_high(0, n); check("R1 pwm0 constant high", n, 256);
        apply(8'd0, lane[2], lane[3]);
        check("R10 out0 zero", int'(duty_cur[7:0]), 0);
        count_high(0, n); check("R1 pwm0 constant low", n, 0);

        // R11: a non-automatic mode forces off.
        mode0 = 2'd1;
        apply(8'd200, lane[2], lane[3]);
        check("R11 manual mode off", int'(duty_cur[7:0]), 0);
        mode0 = 2'd2;
        apply(8'd200, lane[2], lane[3]);
        check("R11 auto again, R5 equal keeps rising", int'(duty_cur[7:0]), 255);

        // R4: switching to lane 3 (30, falling) selects off.
        sel0 = 2'd3;
        apply(lane[0], lane[2], 8'd30);
        check("R4 select lane3", int'(duty_cur[7:0]), 0);

        // R2: a mid-period strobe only takes effect at the wrap.
        do @(negedge clk); while (cyc[7:0] != 8'd10);
        lane[3] = 8'd120;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        do @(negedge clk); while (cyc[7:0] != 8'd200);
        check("R2 held mid period", int'(duty_cur[7:0]), 0);
        do @(negedge clk); while (cyc[7:0] != 8'd255);
        check("R2 held at last count", int'(duty_cur[7:0]), 0);
        @(negedge clk);
        check("R2 loaded after wrap", int'(duty_cur[7:0]), 255);

        // R3: reset mid-run clears duty and restores rising direction.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 mid-run reset duty0", int'(duty_cur[7:0]), 0);
        check("R3 mid-run reset pwm", int'(pwm_out), 0);
        rst_n = 1'b1;
        apply(lane[0], lane[2], 8'd50);
        check("R3 direction rising after reset", int'(duty_cur[7:0]), 0);
        check("R12 out1 after reset", int'(duty_cur[15:8]), 50);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule